// File: doc/BRIEF.md
# Polynomial Signature Compactor

This block compresses the response stream of a circuit under test into a short signature. It holds an N-stage shift register wired in the modular form, with an XOR gate in front of each stage whose coefficient is set. It divides the incoming data, read as a polynomial, by the characteristic polynomial. Whatever the register holds when the stream ends is the remainder of that division, and that remainder is the signature. A single-bit error pattern is x^k, and no polynomial with a constant term divides it, so a single wrong response bit always gives a different signature. A random error survives undetected with a chance of roughly 2^-N.

There are two feed modes. In serial mode one response bit per cycle enters the first stage. In parallel mode a whole output word is used each cycle: bit i of the word is XORed into stage i alongside that stage's feedback term. Because the register is linear, the result in parallel mode is the XOR of the remainders that each output column would give on its own. An init pulse clears the register to zero before a test begins. When the test ends, a compare strobe checks the register against the stored fault-free signature and updates a registered pass flag.

Top module: `sig_analyzer`

## Requirements
- R1: A synchronous reset or an init pulse clears the signature to zero and the pass flag to 0 on the next clock edge. Init takes effect whether or not enable is high, and it wins over an enabled shift in the same cycle.
- R2: While enable is low and neither reset nor init is active, the signature holds its value whatever the data inputs do.
- R3: With mode = 0 (serial) and enable high, each edge sets stage 0 to ser_in XOR (stage N-1 AND tap bit 0). Every other stage i becomes stage i-1 XOR (stage N-1 AND tap bit i). The tap mask holds the polynomial coefficients c0..c(N-1); c0 must be 1.
- R4: The first serial bit is the highest-order coefficient. With the default polynomial 1 + x + x^3 + x^5 (tap mask 5'b01011), starting from zero, the serial stream 1,0,0,0,1,0,1,0 (in time order) leaves stages 0..4 at 1,0,1,1,0, which is signature 5'h0D.
- R5: With mode = 1 (parallel) and enable high, each stage i takes the same value as in R3, except that par_in[i] replaces the serial bit at stage 0 and is XORed in at every other stage i.
- R6: In parallel mode, from a cleared register, the signature of a word sequence A XOR B (word by word) equals the XOR of the signatures of A and of B.
- R7: On a cycle with check high, pass becomes 1 on the next edge if the signature equals exp_sig and 0 if it does not. The comparison uses the signature value held before that edge.
- R8: While check is low and neither reset nor init is active, pass holds its value, whatever exp_sig does.
- R9: In serial mode, from a cleared register, flipping any single bit of a stream changes the final signature.
- R10: In serial mode par_in has no effect on the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Clears the signature and the pass flag before a test |
| en | input | 1 | Advances the register by one step |
| mode | input | 1 | 0 = serial single input, 1 = parallel multiple input |
| ser_in | input | 1 | Serial response bit |
| par_in | input | WIDTH | Parallel response word, bit i goes to stage i |
| exp_sig | input | WIDTH | Fault-free signature |
| check | input | 1 | Compare strobe |
| sig | output | WIDTH | Current register contents (signature) |
| pass | output | 1 | Registered result of the last compare |

## Verification
A wrong feedback tap, a swapped stage or a stuck XOR input corrupts the register on the first step where the top stage is 1. From then on every later step carries the error forward, so the final signature differs from the division model at the next compare. The bench therefore compares the signature after short random streams, with enable toggling between steps. It also uses the hand-derived remainder for the fixed stream and checks the superposition of parallel sequences. An error in the hold or init priority shows on the very next edge, so those cases are sampled exactly one cycle after the stimulus.

// File: rtl/sig_pkg.sv
package sig_pkg;

  typedef enum logic {
    FEED_SERIAL   = 1'b0,
    FEED_PARALLEL = 1'b1
  } feed_mode_e;

  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_HOLD  = 2'd2
  } reg_action_e;

endpackage

// File: rtl/sig_input_sel.sv
module sig_input_sel #(
  parameter int WIDTH = 5
) (
  input  logic             mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] din
);
  import sig_pkg::*;

  feed_mode_e mode_e;
  assign mode_e = feed_mode_e'(mode);

  // Stage 0 takes either the serial bit or word bit 0.
  assign din[0] = (mode_e == FEED_PARALLEL) ? par_in[0] : ser_in;

  // Upper stages see data only in parallel mode.
  for (genvar g = 1; g < WIDTH; g++) begin : g_upper
    assign din[g] = (mode_e == FEED_PARALLEL) ? par_in[g] : 1'b0;
  end

endmodule

// File: rtl/sig_next_state.sv
module sig_next_state #(
  parameter int             WIDTH = 5,
  parameter logic [WIDTH-1:0] TAPS  = 5'b01011
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic fb;
  assign fb = cur[TOP];

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      if (TAPS[0]) begin : g_tap
        assign nxt[0] = din[0] ^ fb;
      end else begin : g_notap
        assign nxt[0] = din[0];
      end
    end else begin : g_body
      if (TAPS[g]) begin : g_tap
        assign nxt[g] = cur[g-1] ^ fb ^ din[g];
      end else begin : g_notap
        assign nxt[g] = cur[g-1] ^ din[g];
      end
    end
  end

endmodule

// File: rtl/sig_match.sv
module sig_match #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             check,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] exp_sig,
  output logic             pass
);
  logic equal;
  assign equal = (cur == exp_sig);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pass <= 1'b0;
    end else if (check) begin
      pass <= equal;
    end
  end

endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer #(
  parameter int               WIDTH = 5,
  parameter logic [WIDTH-1:0] TAPS  = 5'b01011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             en,
  input  logic             mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic [WIDTH-1:0] exp_sig,
  input  logic             check,
  output logic [WIDTH-1:0] sig,
  output logic             pass
);
  import sig_pkg::*;

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] din;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] state_q;
  reg_action_e      act;

  sig_input_sel #(.WIDTH(WIDTH)) sel_i (
    .mode   (mode),
    .ser_in (ser_in),
    .par_in (par_in),
    .din    (din)
  );

  sig_next_state #(.WIDTH(WIDTH), .TAPS(TAPS)) ns_i (
    .cur (state_q),
    .din (din),
    .nxt (nxt)
  );

  always_comb begin
    if (rst || init) begin
      act = ACT_CLEAR;
    end else if (en) begin
      act = ACT_STEP;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: state_q <= ZERO;
      ACT_STEP:  state_q <= nxt;
      default:   state_q <= state_q;
    endcase
  end

  sig_match #(.WIDTH(WIDTH)) cmp_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (init),
    .check   (check),
    .cur     (state_q),
    .exp_sig (exp_sig),
    .pass    (pass)
  );

  assign sig = state_q;

endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
  parameter int WIDTH = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             init,
  input logic             en,
  input logic             mode,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] exp_sig,
  input logic             check,
  input logic [WIDTH-1:0] sig,
  input logic             pass
);
  localparam int TOP = WIDTH - 1;

  AST_CLEAR_ON_INIT: assert property (@(posedge clk) disable iff (rst)
    init |=> (sig == '0) && !pass); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!init && !en) |=> $stable(sig)); // R2

  AST_SERIAL_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!init && en && !mode && !sig[TOP]) |=>
      sig == {$past(sig[TOP-1:0]), $past(ser_in)}); // R3

  AST_PARALLEL_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!init && en && mode && !sig[TOP]) |=>
      sig == ({$past(sig[TOP-1:0]), 1'b0} ^ $past(par_in))); // R5

  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!init && check) |=> pass == ($past(sig) == $past(exp_sig))); // R7

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!init && !check) |=> $stable(pass)); // R8

endmodule

bind sig_analyzer sig_analyzer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .init    (init),
  .en      (en),
  .mode    (mode),
  .ser_in  (ser_in),
  .par_in  (par_in),
  .exp_sig (exp_sig),
  .check   (check),
  .sig     (sig),
  .pass    (pass)
);

// File: tb/sig_analyzer_tb.sv
module sig_analyzer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, init, en, mode, check;
  logic s5_ser;
  logic [4:0] s5_par, s5_exp;
  wire  [4:0] s5_sig;
  wire        s5_pass;
  logic [2:0] s3_par, s3_exp;
  wire  [2:0] s3_sig;
  wire        s3_pass;

  int n_chk  = 0;
  int n_fail = 0;

  sig_analyzer dut_i (
    .clk(clk), .rst(rst), .init(init), .en(en), .mode(mode),
    .ser_in(s5_ser), .par_in(s5_par), .exp_sig(s5_exp), .check(check),
    .sig(s5_sig), .pass(s5_pass)
  );

  sig_analyzer #(.WIDTH(3), .TAPS(3'b011)) dut3_i (
    .clk(clk), .rst(rst), .init(init), .en(en), .mode(mode),
    .ser_in(1'b0), .par_in(s3_par), .exp_sig(s3_exp), .check(check),
    .sig(s3_sig), .pass(s3_pass)
  );

  // Division model: one step of the modular divider of width w.
  function automatic logic [7:0] mstep(input logic [7:0] s, input logic [7:0] d,
                                       input int w, input logic [7:0] taps);
    logic [7:0] r;
    r = {s[6:0], 1'b0} ^ d;
    if (s[w-1]) r = r ^ taps;
    return r & (8'hFF >> (8 - w));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_init();
    init = 1'b1; en = 1'b0; check = 1'b0;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic feed_serial(input logic [15:0] bits, input int len, output logic [4:0] res);
    pulse_init();
    mode = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      en = 1'b1; s5_ser = bits[i];
      @(negedge clk);
    end
    en = 1'b0;
    res = s5_sig;
  endtask

  task automatic feed_par3(input logic [2:0] w [8], output logic [2:0] res);
    pulse_init();
    mode = 1'b1;
    for (int i = 0; i < 8; i++) begin
      en = 1'b1; s3_par = w[i];
      @(negedge clk);
    end
    en = 1'b0;
    res = s3_sig;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] m5, r5, base;
    logic [2:0] m3, sa, sb, sab;
    logic [2:0] wa [8];
    logic [2:0] wb [8];
    logic [2:0] wx [8];
    logic [15:0] stream;
    logic [7:0] bits_ref;
    void'($urandom(32'd4021));
    rst = 1'b1; init = 1'b0; en = 1'b0; mode = 1'b0; check = 1'b0;
    s5_ser = 1'b0; s5_par = '0; s5_exp = '0; s3_par = '0; s3_exp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(s5_sig == 5'h00, "R1 reset sig", s5_sig, 0);
    chk(s5_pass == 1'b0, "R1 reset pass", s5_pass, 0);

    // R4 reference stream, first bit in time = highest order
    bits_ref = 8'b1000_1010;
    pulse_init();
    for (int i = 7; i >= 0; i--) begin
      en = 1'b1; s5_ser = bits_ref[i]; s5_par = 5'($urandom);
      @(negedge clk);
    end
    en = 1'b0;
    chk(s5_sig == 5'h0D, "R4 reference signature", s5_sig, 5'h0D);

    // R7 matching compare
    s5_exp = 5'h0D; check = 1'b1;
    @(negedge clk);
    check = 1'b0;
    chk(s5_pass == 1'b1, "R7 compare match", s5_pass, 1);

    // R2 / R8 idle with changing data and expected value
    for (int i = 0; i < 4; i++) begin
      s5_ser = 1'($urandom); s5_par = 5'($urandom); s5_exp = 5'($urandom);
      @(negedge clk);
      chk(s5_sig == 5'h0D, "R2 hold while disabled", s5_sig, 5'h0D);
      chk(s5_pass == 1'b1, "R8 pass holds without strobe", s5_pass, 1);
    end

    // R7 mismatch
    s5_exp = 5'h1F; check = 1'b1;
    @(negedge clk);
    check = 1'b0;
    chk(s5_pass == 1'b0, "R7 compare mismatch", s5_pass, 0);
    s5_exp = 5'h0D; check = 1'b1;
    @(negedge clk);
    check = 1'b0;

    // R1 init with enable low
    init = 1'b1; en = 1'b0;
    @(negedge clk);
    init = 1'b0;
    chk(s5_sig == 5'h00, "R1 init clears sig", s5_sig, 0);
    chk(s5_pass == 1'b0, "R1 init clears pass", s5_pass, 0);

    // R1 init wins over enabled shift
    en = 1'b1; mode = 1'b0; s5_ser = 1'b1;
    @(negedge clk);
    chk(s5_sig == 5'h01, "R3 first bit enters stage 0", s5_sig, 1);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0; en = 1'b0;
    chk(s5_sig == 5'h00, "R1 init over enable", s5_sig, 0);

    // R3 / R10 / R2 random serial streams with random par_in and enable gaps
    for (int t = 0; t < 12; t++) begin
      pulse_init();
      mode = 1'b0; m5 = '0;
      for (int i = 0; i < 20; i++) begin
        en = 1'($urandom); s5_ser = 1'($urandom); s5_par = 5'($urandom);
        if (en) m5 = 5'(mstep({3'b0, m5}, {7'b0, s5_ser}, 5, 8'h0B));
        @(negedge clk);
      end
      en = 1'b0;
      chk(s5_sig == m5, "R3 R10 serial division", s5_sig, m5);
    end

    // R9 single-bit flips
    stream = 16'($urandom) & 16'h0FFF;
    feed_serial(stream, 12, base);
    for (int k = 0; k < 12; k++) begin
      feed_serial(stream ^ (16'h1 << k), 12, r5);
      chk(r5 != base, "R9 flipped bit changes signature", r5, base);
    end

    // R5 parallel mode on both widths
    for (int t = 0; t < 6; t++) begin
      pulse_init();
      mode = 1'b1; m5 = '0; m3 = '0;
      for (int i = 0; i < 10; i++) begin
        en = 1'b1; s5_par = 5'($urandom); s3_par = 3'($urandom);
        m5 = 5'(mstep({3'b0, m5}, {3'b0, s5_par}, 5, 8'h0B));
        m3 = 3'(mstep({5'b0, m3}, {5'b0, s3_par}, 3, 8'h03));
        @(negedge clk);
      end
      en = 1'b0;
      chk(s5_sig == m5, "R5 parallel 5-stage", s5_sig, m5);
      chk(s3_sig == m3, "R5 parallel 3-stage", s3_sig, m3);
    end

    // R5 corner: all-ones words into 3-stage
    pulse_init();
    mode = 1'b1; m3 = '0;
    for (int i = 0; i < 7; i++) begin
      en = 1'b1; s3_par = 3'b111;
      m3 = 3'(mstep({5'b0, m3}, 8'h07, 3, 8'h03));
      @(negedge clk);
    end
    en = 1'b0;
    chk(s3_sig == m3, "R5 all-ones words", s3_sig, m3);

    // R6 superposition
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 8; i++) begin
        wa[i] = 3'($urandom); wb[i] = 3'($urandom); wx[i] = wa[i] ^ wb[i];
      end
      feed_par3(wa, sa);
      feed_par3(wb, sb);
      feed_par3(wx, sab);
      chk(sab == (sa ^ sb), "R6 superposition", sab, sa ^ sb);
    end

    // R7 on 3-stage
    s3_exp = sab; check = 1'b1;
    @(negedge clk);
    check = 1'b0;
    chk(s3_pass == 1'b1, "R7 3-stage match", s3_pass, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule